// File: doc/BRIEF.md
# USB Device Packet Transmit Assembler

This block builds outgoing packets for a USB device. The transaction controller pulses a start strobe together with a packet kind. For a handshake the block sends one PID byte. For a data packet it sends a DATA0 or DATA1 PID, then the payload bytes the application supplies, then a CRC16 that it computes while the bytes go out. A zero-length data packet is chosen with a flag sampled at start.

Bytes leave on a UTMI-style transmit byte interface. The transmit-valid output stays high for the whole packet, and a byte advances only when the PHY raises its ready input. The payload source sees a take pulse for each byte the PHY accepts. It presents the next byte, with a last-byte flag, combinationally. A one-cycle done pulse marks the end of each packet. Serialisation, NRZI encoding and line drive belong to the PHY.

Top module: `usb_tx_packer`

## Requirements
- R1: After reset, tx_valid_o, done_o and pl_take_o are all low.
- R2: The first byte of every packet is a PID byte. Its low nibble holds the 4-bit code and its high nibble holds the ones' complement of the code. The kind_i encodings and codes are: 0 ACK 0010, 1 NAK 1010, 2 STALL 1110, 3 NYET 0110, 4 DATA0 0011, 5 DATA1 1011.
- R3: A handshake (kind 0 to 3) is exactly one byte long, with no payload and no CRC.
- R4: A data packet sends the payload bytes after the PID, in order. pl_take_o is high in exactly those cycles where a payload byte is on tx_data_o and tx_ready_i is high. The byte flagged by pl_last_i is the final payload byte.
- R5: After the payload, a data packet sends the ones' complement of a CRC16, low byte first. The CRC uses polynomial x^16+x^15+x^2+1 with a preset of all ones, taken LSB first. For the ASCII payload "123456789" the two bytes are 0xC8 then 0xB4.
- R6: With zlp_i high at start, a data packet is the PID followed by 0x00, 0x00, and pl_take_o never rises.
- R7: tx_valid_o stays high from the PID through the final byte. While tx_ready_i is low, the byte on tx_data_o does not advance.
- R8: done_o is a single-cycle pulse. It appears in the cycle after the final byte of a packet is accepted.
- R9: A start pulse is ignored while a packet is in progress, and also when kind_i is 6 or 7.
- R10: tx_valid_o is low for at least one cycle between packets, including the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send a packet |
| kind_i | input | 3 | Packet kind, sampled with start_i |
| zlp_i | input | 1 | Zero-length data packet, sampled with start_i |
| pl_data_i | input | 8 | Current payload byte |
| pl_last_i | input | 1 | pl_data_i is the final payload byte |
| pl_take_o | output | 1 | Payload byte consumed this cycle |
| tx_data_o | output | 8 | Byte toward the PHY |
| tx_valid_o | output | 1 | Packet in progress, byte valid |
| tx_ready_i | input | 1 | PHY accepts the byte this cycle |
| done_o | output | 1 | Packet finished (one cycle) |

## Verification
The bench sweeps every packet kind, with payload lengths from zero to twelve and one of forty, under three ready patterns: always ready, alternating, and pseudo-random stalls. It targets the zero-length case, where a design that does not skip the body state would emit a garbage byte or raise pl_take_o. It targets stalls landing on the PID and CRC bytes, where a design that advances without ready would drop a byte or skew the CRC. The fixed "123456789" payload catches a reflected or non-inverted CRC. Start pulses sent mid-packet and with unused kind codes catch a design that restarts or sends a bogus PID.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

   typedef enum logic [2:0] {
      KIND_ACK   = 3'd0,
      KIND_NAK   = 3'd1,
      KIND_STALL = 3'd2,
      KIND_NYET  = 3'd3,
      KIND_DATA0 = 3'd4,
      KIND_DATA1 = 3'd5
   } pkt_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PID,
      ST_BODY,
      ST_CRC_LO,
      ST_CRC_HI
   } tx_state_e;

   localparam logic [3:0] CODE_ACK   = 4'b0010;
   localparam logic [3:0] CODE_NAK   = 4'b1010;
   localparam logic [3:0] CODE_STALL = 4'b1110;
   localparam logic [3:0] CODE_NYET  = 4'b0110;
   localparam logic [3:0] CODE_DATA0 = 4'b0011;
   localparam logic [3:0] CODE_DATA1 = 4'b1011;

endpackage

// File: rtl/usb_tx_pid_enc.sv
module usb_tx_pid_enc
   import usb_tx_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [2:0]        kind_i,
   output logic [BYTE_W-1:0] pid_o,
   output logic              is_data_o,
   output logic              legal_o
);
   localparam int NIB_W = BYTE_W / 2;

   generate
      if (NIB_W != 4) begin : g_bad_width
         $error("usb_tx_pid_enc: BYTE_W must be 8");
      end
   endgenerate

   logic [NIB_W-1:0] code;

   always_comb begin
      code      = '0;
      is_data_o = 1'b0;
      legal_o   = 1'b1;
      case (kind_i)
         KIND_ACK:   code = CODE_ACK;
         KIND_NAK:   code = CODE_NAK;
         KIND_STALL: code = CODE_STALL;
         KIND_NYET:  code = CODE_NYET;
         KIND_DATA0: begin code = CODE_DATA0; is_data_o = 1'b1; end
         KIND_DATA1: begin code = CODE_DATA1; is_data_o = 1'b1; end
         default:    legal_o = 1'b0;
      endcase
   end

   assign pid_o = {~code, code};

endmodule

// File: rtl/usb_tx_crc_step.sv
module usb_tx_crc_step #(
   parameter int                CRC_W    = 16,
   parameter int                BYTE_W   = 8,
   parameter logic [CRC_W-1:0]  POLY_REV = 16'hA001
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [CRC_W-1:0]  crc_o
);
   generate
      if (BYTE_W < 1 || BYTE_W > CRC_W) begin : g_bad_cfg
         $error("usb_tx_crc_step: BYTE_W out of range");
      end
   endgenerate

   // LSB-first serial division, one bit per loop pass
   always_comb begin
      logic [CRC_W-1:0] acc;
      acc = crc_i;
      for (int b = 0; b < BYTE_W; b++) begin
         if (acc[0] ^ byte_i[b]) acc = (acc >> 1) ^ POLY_REV;
         else                    acc = acc >> 1;
      end
      crc_o = acc;
   end

endmodule

// File: rtl/usb_tx_packer.sv
module usb_tx_packer
   import usb_tx_pkg::*;
#(
   parameter int               BYTE_W   = 8,
   parameter int               CRC_W    = 16,
   parameter logic [CRC_W-1:0] POLY_REV = 16'hA001,
   parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        kind_i,
   input  logic              zlp_i,
   input  logic [BYTE_W-1:0] pl_data_i,
   input  logic              pl_last_i,
   output logic              pl_take_o,
   output logic [BYTE_W-1:0] tx_data_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic              done_o
);
   localparam int CRC_BYTES = CRC_W / BYTE_W;

   generate
      if (CRC_BYTES != 2 || CRC_W % BYTE_W != 0) begin : g_bad_cfg
         $error("usb_tx_packer: CRC_W must be two bytes");
      end
   endgenerate

   tx_state_e         state_q;
   logic [BYTE_W-1:0] pid_q;
   logic              data_q;
   logic              zlp_q;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  crc_nx;
   logic              done_q;

   logic [BYTE_W-1:0] pid_w;
   logic              is_data_w;
   logic              legal_w;

   usb_tx_pid_enc #(.BYTE_W(BYTE_W)) pid_enc_i (
      .kind_i    (kind_i),
      .pid_o     (pid_w),
      .is_data_o (is_data_w),
      .legal_o   (legal_w)
   );

   usb_tx_crc_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY_REV(POLY_REV)) crc_i (
      .crc_i  (crc_q),
      .byte_i (pl_data_i),
      .crc_o  (crc_nx)
   );

   logic accept;
   logic final_byte;

   assign tx_valid_o = (state_q != ST_IDLE);
   assign accept     = tx_valid_o && tx_ready_i;
   assign final_byte = (state_q == ST_CRC_HI) || ((state_q == ST_PID) && !data_q);
   assign pl_take_o  = (state_q == ST_BODY) && tx_ready_i;
   assign done_o     = done_q;

   always_comb begin
      case (state_q)
         ST_PID:    tx_data_o = pid_q;
         ST_BODY:   tx_data_o = pl_data_i;
         ST_CRC_LO: tx_data_o = ~crc_q[BYTE_W-1:0];
         ST_CRC_HI: tx_data_o = ~crc_q[CRC_W-1:BYTE_W];
         default:   tx_data_o = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pid_q   <= '0;
         data_q  <= 1'b0;
         zlp_q   <= 1'b0;
         crc_q   <= CRC_SEED;
         done_q  <= 1'b0;
      end else begin
         done_q <= accept && final_byte;
         case (state_q)
            ST_IDLE: begin
               if (start_i && legal_w) begin
                  pid_q   <= pid_w;
                  data_q  <= is_data_w;
                  zlp_q   <= zlp_i;
                  crc_q   <= CRC_SEED;
                  state_q <= ST_PID;
               end
            end
            ST_PID: begin
               if (tx_ready_i) begin
                  if (!data_q)    state_q <= ST_IDLE;
                  else if (zlp_q) state_q <= ST_CRC_LO;
                  else            state_q <= ST_BODY;
               end
            end
            ST_BODY: begin
               if (tx_ready_i) begin
                  crc_q <= crc_nx;
                  if (pl_last_i) state_q <= ST_CRC_LO;
               end
            end
            ST_CRC_LO: if (tx_ready_i) state_q <= ST_CRC_HI;
            ST_CRC_HI: if (tx_ready_i) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/usb_tx_packer_chk.sv
module usb_tx_packer_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        kind_i,
   input logic              pl_take_o,
   input logic [BYTE_W-1:0] tx_data_o,
   input logic              tx_valid_o,
   input logic              tx_ready_i,
   input logic              done_o
);
   localparam int NIB_W = BYTE_W / 2;

   // R7
   hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o && !tx_ready_i |=> tx_valid_o);

   // R2
   pid_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> tx_data_o[BYTE_W-1:NIB_W] == ~tx_data_o[NIB_W-1:0]);

   // R4
   take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pl_take_o |-> tx_valid_o && tx_ready_i);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(tx_valid_o && tx_ready_i));

   // R10
   gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !tx_valid_o);

   // R9
   bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid_o && start_i && (kind_i > 3'd5) |=> !tx_valid_o);

endmodule

bind usb_tx_packer usb_tx_packer_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .kind_i     (kind_i),
   .pl_take_o  (pl_take_o),
   .tx_data_o  (tx_data_o),
   .tx_valid_o (tx_valid_o),
   .tx_ready_i (tx_ready_i),
   .done_o     (done_o)
);

// File: tb/usb_tx_packer_tb_top.sv
`timescale 1ns/1ps
module usb_tx_packer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] kind_i = '0;
   logic       zlp_i = 1'b0;
   logic [7:0] pl_data_i = '0;
   logic       pl_last_i = 1'b0;
   logic       pl_take_o;
   logic [7:0] tx_data_o;
   logic       tx_valid_o;
   logic       tx_ready_i = 1'b0;
   logic       done_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   usb_tx_packer dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
      .zlp_i(zlp_i), .pl_data_i(pl_data_i), .pl_last_i(pl_last_i),
      .pl_take_o(pl_take_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
      .tx_ready_i(tx_ready_i), .done_o(done_o)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] code_of(input int k);
      case (k)
         0: return 4'b0010;
         1: return 4'b1010;
         2: return 4'b1110;
         3: return 4'b0110;
         4: return 4'b0011;
         default: return 4'b1011;
      endcase
   endfunction

   // MSB-first register form; result mirrored into wire order afterwards
   function automatic logic [15:0] crc_wire(input logic [7:0] b [0:63], input int n);
      logic [15:0] c = 16'hFFFF;
      logic [15:0] r;
      for (int i = 0; i < n; i++)
         for (int j = 0; j < 8; j++) begin
            logic fb;
            fb = b[i][j] ^ c[15];
            c  = c << 1;
            if (fb) c = c ^ 16'h8005;
         end
      for (int j = 0; j < 16; j++) r[j] = c[15-j];
      return ~r;
   endfunction

   logic [7:0] pay [0:63];
   logic [7:0] expb [0:67];
   logic [15:0] lfsr = 16'hACE1;

   function automatic logic ready_for(input int mode, input int cyc, input logic [15:0] l);
      if (mode == 0) return 1'b1;
      if (mode == 1) return cyc[0];
      return l[0] | l[3];
   endfunction

   task automatic run_packet(input int kind, input int len, input int mode,
                             input bit poke, input bit anchor);
      int n;
      int pos = 0;
      int idx = 0;
      int cyc = 0;
      bit is_data = (kind >= 4);
      logic [15:0] cw;
      if (!anchor)
         for (int i = 0; i < 64; i++) pay[i] = 8'((i * 29) + (len * 7) + kind);
      expb[0] = {~code_of(kind), code_of(kind)};
      n = 1;
      if (is_data) begin
         for (int i = 0; i < len; i++) expb[1 + i] = pay[i];
         cw = crc_wire(pay, len);
         expb[1 + len] = cw[7:0];
         expb[2 + len] = cw[15:8];
         n = len + 3;
         if (anchor) begin expb[1 + len] = 8'hC8; expb[2 + len] = 8'hB4; end
      end
      @(negedge clk);
      start_i = 1'b1; kind_i = 3'(kind); zlp_i = is_data && (len == 0);
      @(negedge clk);
      start_i = 1'b0;
      while (pos < n) begin
         bit in_body;
         in_body = is_data && pos >= 1 && pos < 1 + len;
         pl_data_i = pay[idx];
         pl_last_i = (idx == len - 1);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_ready_i = ready_for(mode, cyc, lfsr);
         if (poke && cyc == 2) begin start_i = 1'b1; kind_i = 3'd0; end
         else start_i = 1'b0;
         #1;
         check("R7 tx_valid_o held", 16'(tx_valid_o), 16'd1);
         if (pos == 0)
            check(is_data ? "R2 data PID" : "R2/R3 handshake PID", 16'(tx_data_o), 16'(expb[0]));
         else if (in_body)
            check("R4 payload byte", 16'(tx_data_o), 16'(expb[pos]));
         else
            check(len == 0 ? "R6 zero-length CRC byte" : "R5 CRC byte",
                  16'(tx_data_o), 16'(expb[pos]));
         check(len == 0 ? "R6 pl_take_o" : "R4 pl_take_o",
               16'(pl_take_o), 16'(tx_ready_i && in_body));
         @(posedge clk);
         if (tx_ready_i) begin
            pos++;
            if (in_body) idx++;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      tx_ready_i = 1'b0;
      #1;
      check("R8 done_o after final byte", 16'(done_o), 16'd1);
      check("R10 tx_valid_o gap", 16'(tx_valid_o), 16'd0);
      @(negedge clk);
      #1;
      check("R8 done_o single cycle", 16'(done_o), 16'd0);
      check("R9 mid-packet start ignored", 16'(tx_valid_o), 16'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 tx_valid_o reset", 16'(tx_valid_o), 16'd0);
      check("R1 done_o reset", 16'(done_o), 16'd0);
      tx_ready_i = 1'b1;
      #1;
      check("R1 pl_take_o reset", 16'(pl_take_o), 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      tx_ready_i = 1'b0;
      #1;
      check("R1 tx_valid_o after reset", 16'(tx_valid_o), 16'd0);

      // R9 unused kind codes
      for (int k = 6; k < 8; k++) begin
         @(negedge clk);
         start_i = 1'b1; kind_i = 3'(k);
         @(negedge clk);
         start_i = 1'b0;
         for (int c = 0; c < 3; c++) begin
            #1;
            check("R9 unused kind ignored", 16'(tx_valid_o), 16'd0);
            check("R9 no done on unused kind", 16'(done_o), 16'd0);
            @(negedge clk);
         end
      end

      // R5 fixed anchor payload "123456789"
      for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
      run_packet(4, 9, 0, 1'b0, 1'b1);

      for (int mode = 0; mode < 3; mode++) begin
         for (int k = 0; k < 4; k++) run_packet(k, 0, mode, mode == 1, 1'b0);
         for (int k = 4; k < 6; k++) begin
            for (int len = 0; len <= 12; len++) run_packet(k, len, mode, mode == 1, 1'b0);
            run_packet(k, 40, mode, 1'b0, 1'b0);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule